// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This unit sits next to the fetch stage of a small 32-bit load/store core. It watches 32 interrupt request lines, each with equal standing. When an instruction finishes, the core raises `insn_done`. If interrupts are globally on and at least one requesting line is unmasked, the unit takes the interrupt in that same cycle. It tells the core to redirect fetch to a fixed handler vector. It asks for the return register to be written with the next-instruction address. On the following clock edge it saves the global enable bit into a shadow register and clears the live copy.

A return-from-exception strobe undoes the entry. The shadow bit goes back into the live enable, and fetch is sent to the address the core supplies from the return register. Devices are acknowledged by software, not by a hardware wire. A request that stays high is therefore taken again as soon as the enables allow it. The handler reaches the control registers through a numbered write port and a combinational read port. Register 4 exposes the requesting lines gated by the mask, so the handler can find the source.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, registers 0, 1 and 3 read as zero, and no interrupt is taken.
- R2: `take` is high exactly when `insn_done` is high, `eret` is low, bit 0 of register 0 is 1, and some line i has `irq[i]` and bit i of register 3 both 1. Any line qualifies, and no line is preferred.
- R3: While bit 0 of register 0 is 0, requests have no effect: `take`, `ea_we` and `redir_valid` stay low.
- R4: On the edge after a take, register 1 bit 0 holds the value that register 0 bit 0 had before the take, and register 0 bit 0 is 0.
- R5: In a take cycle, `ea_we` is 1 with `ea_wdata` equal to `pc_in + 4`, and `redir_valid` is 1 with `redir_pc` equal to 0x20.
- R6: In an `eret` cycle, `redir_valid` is 1 with `redir_pc` equal to `ea_in`, and `take` is 0 even if a request is pending. On the next edge, register 0 bit 0 takes the value of register 1 bit 0.
- R7: A request line held high through an `eret` that restores the enable is taken again at the next `insn_done`.
- R8: Writing to register 0 or 1 stores only bit 0, and the other bits read as 0. Writing to register 3 stores all 32 bits. Register numbers 2, 5, 6 and 7 ignore writes and read as 0, and register 4 ignores writes.
- R9: Register 4 reads as `irq` AND register 3.
- R10: A take overrides a same-cycle write to register 0 or 1. An `eret` overrides a same-cycle write to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 32 | Level request lines |
| insn_done | input | 1 | Current instruction completes this cycle |
| pc_in | input | 32 | Address of the completing instruction |
| eret | input | 1 | Return-from-exception strobe |
| ea_in | input | 32 | Current value of the return register |
| ctl_we | input | 1 | Control register write enable |
| ctl_wsel | input | 3 | Control register number for the write |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rsel | input | 3 | Control register number for the read |
| ctl_rdata | output | 32 | Control register read data |
| take | output | 1 | Interrupt accepted this cycle |
| ea_we | output | 1 | Write the return register this cycle |
| ea_wdata | output | 32 | Value for the return register |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_pc | output | 32 | Fetch redirect target |

## Verification
A software write to the global-enable or shadow register can land in the same cycle as an acceptance. An `eret` can likewise meet a pending request at an instruction boundary, or a write to register 0. Directed cases place a write of 1 to register 0 exactly on the take cycle. They then read back a 0. They also fire `eret` while a request is pending, and expect no take together with a restored enable. The random phase raises writes, boundaries, returns and requests independently, so these collisions recur. Each cycle's outputs and register reads are compared with a reference model in the bench that applies the precedence rules.

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int          NLINES = 32,
  parameter int          XLEN   = 32,
  parameter int          SELW   = 3,
  parameter logic [31:0] VECTOR = 32'h0000_0020
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINES-1:0] irq,
  input  logic             insn_done,
  input  logic [XLEN-1:0]  pc_in,
  input  logic             eret,
  input  logic [XLEN-1:0]  ea_in,
  input  logic             ctl_we,
  input  logic [SELW-1:0]  ctl_wsel,
  input  logic [XLEN-1:0]  ctl_wdata,
  input  logic [SELW-1:0]  ctl_rsel,
  output logic [XLEN-1:0]  ctl_rdata,
  output logic             take,
  output logic             ea_we,
  output logic [XLEN-1:0]  ea_wdata,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc
);
  localparam logic [SELW-1:0] SEL_STAT = SELW'(0);
  localparam logic [SELW-1:0] SEL_SAVE = SELW'(1);
  localparam logic [SELW-1:0] SEL_MASK = SELW'(3);
  localparam logic [SELW-1:0] SEL_PEND = SELW'(4);

  logic              gie_q, gie_save_q;
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] pend;

  assign pend        = irq & mask_q;
  assign take        = insn_done && !eret && gie_q && (|pend);
  assign ea_we       = take;
  assign ea_wdata    = pc_in + XLEN'(4);
  assign redir_valid = take || eret;
  assign redir_pc    = eret ? ea_in : XLEN'(VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      gie_save_q <= 1'b0;
      mask_q     <= '0;
    end else begin
      if (eret)                              gie_q <= gie_save_q;
      else if (take)                         gie_q <= 1'b0;
      else if (ctl_we && ctl_wsel == SEL_STAT) gie_q <= ctl_wdata[0];

      if (take)                              gie_save_q <= gie_q;
      else if (ctl_we && ctl_wsel == SEL_SAVE) gie_save_q <= ctl_wdata[0];

      if (ctl_we && ctl_wsel == SEL_MASK)    mask_q <= ctl_wdata[NLINES-1:0];
    end
  end

  always_comb begin
    ctl_rdata = '0;
    case (ctl_rsel)
      SEL_STAT: ctl_rdata[0]        = gie_q;
      SEL_SAVE: ctl_rdata[0]        = gie_save_q;
      SEL_MASK: ctl_rdata[NLINES-1:0] = mask_q;
      SEL_PEND: ctl_rdata[NLINES-1:0] = pend;
      default:  ctl_rdata           = '0;
    endcase
  end

  AST_TAKE_SAVES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!gie_q && gie_save_q == $past(gie_q))); // R4
  AST_ERET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    eret |=> (gie_q == $past(gie_save_q))); // R6
  AST_TAKE_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ctl_we && ctl_wsel == SEL_STAT) |=> !gie_q); // R10
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wsel == SEL_MASK) |=> (mask_q == $past(ctl_wdata[NLINES-1:0]))); // R8
  AST_GIE_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !eret) |-> (!ea_we && !redir_valid)); // R3
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we |-> (ea_wdata - pc_in == XLEN'(4) && redir_pc == XLEN'(VECTOR))); // R5
endmodule

// File: tb/sim_irq_accept_unit.sv
module sim_irq_accept_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0, pc_in = '0, ea_in = '0, ctl_wdata = '0;
  logic        insn_done = 1'b0, eret = 1'b0, ctl_we = 1'b0;
  logic [2:0]  ctl_wsel = '0, ctl_rsel = '0;
  logic [31:0] ctl_rdata, ea_wdata, redir_pc;
  logic        take, ea_we, redir_valid;

  int errors = 0, checks = 0;
  logic        m_gie = 1'b0, m_save = 1'b0;
  logic [31:0] m_mask = '0;

  always #4 clk = ~clk;

  irq_accept_unit u0 (.clk, .rst_n, .irq, .insn_done, .pc_in, .eret, .ea_in,
    .ctl_we, .ctl_wsel, .ctl_wdata, .ctl_rsel, .ctl_rdata, .take, .ea_we,
    .ea_wdata, .redir_valid, .redir_pc);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] sel);
    case (sel)
      3'd0: return {31'd0, m_gie};
      3'd1: return {31'd0, m_save};
      3'd3: return m_mask;
      3'd4: return irq & m_mask;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_take();
    return insn_done && !eret && m_gie && (|(irq & m_mask));
  endfunction

  // inputs are set after a falling edge; checks sample mid-phase, then the edge advances the model
  task automatic tick();
    logic et, ng, ns;
    logic [31:0] nm;
    #1;
    et = exp_take();
    check((!m_gie && insn_done && |(irq & m_mask)) ? "R3" : "R2", {31'd0, take}, {31'd0, et});
    check("R5", {31'd0, ea_we}, {31'd0, et});
    check("R6", {31'd0, redir_valid}, {31'd0, et | eret});
    if (et) begin
      check("R5", ea_wdata, pc_in + 32'd4);
      check("R5", redir_pc, 32'h20);
    end
    if (eret) check("R6", redir_pc, ea_in);
    check(ctl_rsel == 3'd4 ? "R9" : "R8", ctl_rdata, exp_read(ctl_rsel));
    ng = eret ? m_save : et ? 1'b0 : (ctl_we && ctl_wsel == 3'd0) ? ctl_wdata[0] : m_gie;
    ns = et ? m_gie : (ctl_we && ctl_wsel == 3'd1) ? ctl_wdata[0] : m_save;
    nm = (ctl_we && ctl_wsel == 3'd3) ? ctl_wdata : m_mask;
    @(posedge clk);
    m_gie = ng; m_save = ns; m_mask = nm;
    @(negedge clk);
    insn_done = 1'b0; eret = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    ctl_we = 1'b1; ctl_wsel = sel; ctl_wdata = d; tick();
  endtask

  task automatic rd(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    ctl_rsel = sel; #1; check(tag, ctl_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 3'd0, 0); rd("R1", 3'd1, 0); rd("R1", 3'd3, 0);
    irq = 32'hFFFF_FFFF; insn_done = 1'b1; tick();           // R1 nothing taken

    wr(3'd3, 32'h8000_0021);                                 // lines 0,5,31
    irq = 32'h0000_0020; insn_done = 1'b1; tick();           // R3 gie off
    rd("R9", 3'd4, 32'h0000_0020);
    wr(3'd0, 32'hFFFF_FFFF);
    rd("R8", 3'd0, 32'd1);
    irq = 32'h0000_0020; tick();                             // R2 no boundary
    pc_in = 32'h0000_1000; insn_done = 1'b1; tick();         // R5 take
    rd("R4", 3'd0, 0); rd("R4", 3'd1, 1);
    insn_done = 1'b1; tick();                                // R3 held line, gie off
    ea_in = 32'h0000_1004; eret = 1'b1; insn_done = 1'b1; tick(); // R6 eret wins
    rd("R6", 3'd0, 1);
    insn_done = 1'b1; pc_in = 32'h0000_1004; tick();         // R7 retake
    check("R7", {31'd0, m_gie}, 32'd0);
    wr(3'd1, 32'd1); ea_in = 32'h40; eret = 1'b1; tick();
    irq = 32'h8000_0000; insn_done = 1'b1; ctl_we = 1'b1; ctl_wsel = 3'd0; ctl_wdata = 32'd1; tick(); // R10
    rd("R10", 3'd0, 0);
    irq = 32'h0000_0001; eret = 1'b1; ctl_we = 1'b1; ctl_wsel = 3'd0; ctl_wdata = 32'd0; tick(); // R10 eret over write
    rd("R10", 3'd0, 1);
    wr(3'd2, 32'hFFFF_FFFF); rd("R8", 3'd2, 0);
    wr(3'd4, 32'hFFFF_FFFF); rd("R8", 3'd4, irq & 32'h8000_0021);
    wr(3'd1, 32'hFFFF_FFFE); rd("R8", 3'd1, 0);

    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 4)
        0: irq = 32'd1 << ($urandom % 32);
        1: irq = $urandom;
        default: irq = '0;
      endcase
      insn_done = ($urandom % 2) == 0;
      eret      = ($urandom % 12) == 0;
      ctl_we    = ($urandom % 4) == 0;
      ctl_wsel  = 3'($urandom % 8);
      ctl_wdata = $urandom;
      ctl_rsel  = 3'($urandom % 8);
      pc_in     = $urandom & 32'hFFFF_FFFC;
      ea_in     = $urandom;
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule